// File: doc/BRIEF.md
# Hot-Swap Circuit Breaker Supervisor

This block is the digital supervisor for a single hot-swap pass switch. It watches a sampled load-current code against two overcurrent limits. The first is a timed primary limit that tolerates short excursions. The second is a fast secondary limit. It is a selectable multiple of the primary one and trips on the first sample above it. The block also takes digitized flags for the supply window, the load-voltage thresholds and external hardware faults. It drives the gate enable of the switch, a discharge output, and three status outputs: current fault, power good and hardware fault.

After a power-on settling count, a rising edge on the enable input starts the switch, provided the supply is inside its window. When either detector trips, the breaker opens and the discharge output goes active. In latch-off mode the breaker stays open until enable is held low for a minimum number of cycles and then raised again. In auto-retry mode it closes again by itself after a cool-off count. The polarity of each status output is a build-time parameter.

Top module: `hotswap_breaker`

## Requirements
- R1: After reset, gate_on_o is 0 and discharge_o is 1, and every status output sits at its inactive level for POR_CYCLES cycles after the synchronized reset release. An enable rising edge seen during that time never closes the switch.
- R2: Once the power-on count has finished, a rising edge of enable_i with supply_ok_i = 1 sets gate_on_o = 1 and discharge_o = 0 one cycle later. With supply_ok_i = 0 the edge is ignored.
- R3: While the switch is on, enable_i = 0 clears gate_on_o and sets discharge_o one cycle later.
- R4: While the switch is on, a sample with load_current_i*20 > PRI_LIMIT*M opens it one cycle later. M is 26, 30, 40 or 35 for thr_sel_i = 00, 01, 10 or 11 (1.3x, 1.5x, 2x, 1.75x). A sample exactly at the limit does not trip.
- R5: While the switch is on, load_current_i > PRI_LIMIT for PRI_CYCLES consecutive samples opens it after the last of them. A single sample at or below PRI_LIMIT restarts the count.
- R6: With retry_mode_i = 0, a tripped breaker stays open until enable_i is low for at least ENL_MIN cycles and then rises. The switch closes one cycle after that rise. A shorter low pulse has no effect.
- R7: With retry_mode_i = 1, a tripped breaker closes again RETRY_CYCLES cycles after the trip, provided enable_i and supply_ok_i are 1, and the current fault clears at the same time.
- R8: ifault_o goes active in the cycle the breaker opens on either detector. It stays active until a qualified enable re-arm or an auto-retry restart.
- R9: While the switch is on, supply_ok_i = 0 opens it one cycle later. It stays open after the supply returns, until the next enable rising edge.
- R10: The internal power-good flag sets one cycle after load_above_hi_i = 1 and clears one cycle after load_below_lo_i = 1. With both flags 0 it holds its value.
- R11: hw_fault_i = 1 latches hwfault_o active and opens the switch one cycle later. Neither re-arm nor start is possible afterwards, and only rst_n clears the latch.
- R12: The parameters PG_ACT_HIGH, IFLT_ACT_HIGH and HWF_ACT_HIGH set the active level of pgood_o, ifault_o and hwfault_o: 1 means active-high, 0 means active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Switch enable; rising edge starts, a long low pulse re-arms |
| retry_mode_i | input | 1 | 0 latch-off, 1 auto-retry |
| thr_sel_i | input | 2 | Secondary threshold multiplier select |
| load_current_i | input | CUR_W | Sampled load-current code |
| supply_ok_i | input | 1 | Supply inside the undervoltage/overvoltage window |
| load_above_hi_i | input | 1 | Load voltage above the power-good high threshold |
| load_below_lo_i | input | 1 | Load voltage below the power-good low threshold |
| hw_fault_i | input | 1 | External hardware fault indication |
| gate_on_o | output | 1 | Pass switch gate enable |
| discharge_o | output | 1 | Load discharge drive |
| ifault_o | output | 1 | Overcurrent fault status |
| pgood_o | output | 1 | Power good status |
| hwfault_o | output | 1 | Latched hardware fault status |

## Verification
Every switching result is registered once. Gate, discharge and current fault respond one cycle after the stimulus sample, and power good and hardware fault respond the same way. The primary trip lands after PRI_CYCLES over-limit samples, and the retry restart lands RETRY_CYCLES cycles after the trip. The bench changes inputs on the falling edge and reads results on a later falling edge. It checks both the last cycle before each timed event and the cycle of the event itself, so an off-by-one shows up in either direction. Random single-sample current pulses with a random multiplier select are compared against a bench model of the secondary threshold. Directed cases hit each select value exactly at its limit and one code above it.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_LATCH = 2'd2,
    ST_COOL  = 2'd3
  } brk_state_e;

  // Secondary limit is PRI_LIMIT * mult / MULT_SCALE
  localparam int MULT_SCALE = 20;

  // Non-monotonic select: 00 1.3x, 01 1.5x, 10 2.0x, 11 1.75x
  function automatic logic [5:0] sec_mult_x20(input logic [1:0] sel);
    logic [5:0] m;
    case (sel)
      2'b00:   m = 6'd26;
      2'b01:   m = 6'd30;
      2'b10:   m = 6'd40;
      default: m = 6'd35;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/hsb_por_timer.sv
module hsb_por_timer #(
  parameter int POR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o
);
  localparam int CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!done_q) begin
      if (cnt_q == CW'(POR_CYCLES - 1)) begin
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  AST_POR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q); // R1

endmodule

// File: rtl/hsb_enable_qual.sv
module hsb_enable_qual #(
  parameter int ENL_MIN = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic rise_o,
  output logic qual_rise_o
);
  localparam int LW = $clog2(ENL_MIN + 1);

  logic          en_q;
  logic [LW-1:0] low_q, low_d;

  always_comb begin
    low_d = low_q;
    if (en_i) begin
      low_d = '0;
    end else if (low_q != LW'(ENL_MIN)) begin
      low_d = low_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      low_q <= '0;
    end else begin
      en_q  <= en_i;
      low_q <= low_d;
    end
  end

  assign rise_o      = en_i & ~en_q;
  assign qual_rise_o = rise_o & (low_q == LW'(ENL_MIN));

  AST_LOW_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    low_q <= LW'(ENL_MIN)); // R6
  AST_HIGH_CLEARS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (low_q == '0)); // R6

endmodule

// File: rtl/hsb_oc_detect.sv
module hsb_oc_detect
  import hsb_pkg::*;
#(
  parameter int CUR_W      = 12,
  parameter int PRI_LIMIT  = 1000,
  parameter int PRI_CYCLES = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed_i,
  input  logic [1:0]       thr_sel_i,
  input  logic [CUR_W-1:0] current_i,
  output logic             pri_trip_o,
  output logic             sec_trip_o
);
  localparam int CNT_W  = $clog2(PRI_CYCLES + 1);
  localparam int PROD_W = CUR_W + 6;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              over_pri;
  logic [PROD_W-1:0] cur_scaled;
  logic [PROD_W-1:0] sec_limit;

  assign over_pri   = current_i > CUR_W'(PRI_LIMIT);
  assign cur_scaled = PROD_W'(current_i) * PROD_W'(MULT_SCALE);
  assign sec_limit  = PROD_W'(PRI_LIMIT) * PROD_W'(sec_mult_x20(thr_sel_i));

  always_comb begin
    cnt_d = cnt_q;
    if (!armed_i || !over_pri) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_W'(PRI_CYCLES - 1)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign pri_trip_o = armed_i & over_pri & (cnt_q == CNT_W'(PRI_CYCLES - 1));
  assign sec_trip_o = armed_i & (cur_scaled > sec_limit);

  AST_PRI_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(PRI_CYCLES)); // R5
  AST_PRI_DIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !over_pri |=> (cnt_q == '0)); // R5
  AST_SEC_ABOVE_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    sec_trip_o |-> over_pri); // R4

endmodule

// File: rtl/hsb_breaker_fsm.sv
module hsb_breaker_fsm
  import hsb_pkg::*;
#(
  parameter int RETRY_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_done_i,
  input  logic enable_i,
  input  logic rise_i,
  input  logic qual_rise_i,
  input  logic supply_ok_i,
  input  logic hw_block_i,
  input  logic retry_mode_i,
  input  logic pri_trip_i,
  input  logic sec_trip_i,
  output logic gate_on_o,
  output logic discharge_o,
  output logic ifault_o
);
  localparam int RW = $clog2(RETRY_CYCLES + 1);

  brk_state_e    st_q, st_d;
  logic [RW-1:0] cool_q, cool_d;
  logic          ifl_q, ifl_d;
  logic          start_ok;
  logic          trip;

  assign start_ok = por_done_i & supply_ok_i & ~hw_block_i;
  assign trip     = pri_trip_i | sec_trip_i;

  always_comb begin
    st_d   = st_q;
    cool_d = '0;
    ifl_d  = ifl_q;
    case (st_q)
      ST_OFF: begin
        if (rise_i && start_ok) st_d = ST_ON;
      end
      ST_ON: begin
        if (trip) begin
          ifl_d = 1'b1;
          st_d  = retry_mode_i ? ST_COOL : ST_LATCH;
        end else if (!enable_i || !supply_ok_i || hw_block_i) begin
          st_d = ST_OFF;
        end
      end
      ST_LATCH: begin
        if (qual_rise_i && start_ok) begin
          st_d  = ST_ON;
          ifl_d = 1'b0;
        end
      end
      ST_COOL: begin
        if (cool_q == RW'(RETRY_CYCLES - 1)) begin
          if (enable_i && start_ok) begin
            st_d  = ST_ON;
            ifl_d = 1'b0;
          end else begin
            st_d = ST_LATCH;
          end
        end else begin
          cool_d = cool_q + 1'b1;
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      cool_q <= '0;
      ifl_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cool_q <= cool_d;
      ifl_q  <= ifl_d;
    end
  end

  assign gate_on_o   = (st_q == ST_ON);
  assign discharge_o = (st_q != ST_ON);
  assign ifault_o    = ifl_q;

  AST_NO_GATE_BEFORE_POR: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done_i |-> !gate_on_o); // R1
  AST_ENABLE_LOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !gate_on_o); // R3
  AST_TRIP_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on_o && trip) |=> (!gate_on_o && ifault_o)); // R8
  AST_SUPPLY_LOSS_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> !gate_on_o); // R9
  AST_COOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cool_q < RW'(RETRY_CYCLES)); // R7

endmodule

// File: rtl/hotswap_breaker.sv
module hotswap_breaker
  import hsb_pkg::*;
#(
  parameter int CUR_W         = 12,
  parameter int PRI_LIMIT     = 1000,
  parameter int PRI_CYCLES    = 50000,
  parameter int RETRY_CYCLES  = 200000,
  parameter int ENL_MIN       = 200,
  parameter int POR_CYCLES    = 1000,
  parameter bit PG_ACT_HIGH   = 1'b1,
  parameter bit IFLT_ACT_HIGH = 1'b1,
  parameter bit HWF_ACT_HIGH  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             retry_mode_i,
  input  logic [1:0]       thr_sel_i,
  input  logic [CUR_W-1:0] load_current_i,
  input  logic             supply_ok_i,
  input  logic             load_above_hi_i,
  input  logic             load_below_lo_i,
  input  logic             hw_fault_i,
  output logic             gate_on_o,
  output logic             discharge_o,
  output logic             ifault_o,
  output logic             pgood_o,
  output logic             hwfault_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sn;
  logic       por_done;
  logic       rise, qual_rise;
  logic       pri_trip, sec_trip;
  logic       gate_on, ifault;
  logic       pg_q, pg_d;
  logic       hw_q, hw_d;
  logic       hw_block;

  // Reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_sync_q[1];

  hsb_por_timer #(.POR_CYCLES(POR_CYCLES)) i_por (
    .clk    (clk),
    .rst_n  (rst_sn),
    .done_o (por_done)
  );

  hsb_enable_qual #(.ENL_MIN(ENL_MIN)) i_enq (
    .clk         (clk),
    .rst_n       (rst_sn),
    .en_i        (enable_i),
    .rise_o      (rise),
    .qual_rise_o (qual_rise)
  );

  hsb_oc_detect #(
    .CUR_W      (CUR_W),
    .PRI_LIMIT  (PRI_LIMIT),
    .PRI_CYCLES (PRI_CYCLES)
  ) i_ocd (
    .clk        (clk),
    .rst_n      (rst_sn),
    .armed_i    (gate_on),
    .thr_sel_i  (thr_sel_i),
    .current_i  (load_current_i),
    .pri_trip_o (pri_trip),
    .sec_trip_o (sec_trip)
  );

  assign hw_block = hw_q | (por_done & hw_fault_i);

  hsb_breaker_fsm #(.RETRY_CYCLES(RETRY_CYCLES)) i_fsm (
    .clk          (clk),
    .rst_n        (rst_sn),
    .por_done_i   (por_done),
    .enable_i     (enable_i),
    .rise_i       (rise),
    .qual_rise_i  (qual_rise),
    .supply_ok_i  (supply_ok_i),
    .hw_block_i   (hw_block),
    .retry_mode_i (retry_mode_i),
    .pri_trip_i   (pri_trip),
    .sec_trip_i   (sec_trip),
    .gate_on_o    (gate_on),
    .discharge_o  (discharge_o),
    .ifault_o     (ifault)
  );

  // Power-good hysteresis and hardware fault latch
  always_comb begin
    pg_d = pg_q;
    hw_d = hw_q;
    if (por_done) begin
      if (load_below_lo_i)      pg_d = 1'b0;
      else if (load_above_hi_i) pg_d = 1'b1;
      if (hw_fault_i)           hw_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pg_q <= 1'b0;
      hw_q <= 1'b0;
    end else begin
      pg_q <= pg_d;
      hw_q <= hw_d;
    end
  end

  assign gate_on_o = gate_on;
  assign ifault_o  = IFLT_ACT_HIGH ? (ifault & por_done) : ~(ifault & por_done);
  assign pgood_o   = PG_ACT_HIGH   ? pg_q                : ~pg_q;
  assign hwfault_o = HWF_ACT_HIGH  ? hw_q                : ~hw_q;

  AST_HW_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    hw_q |=> hw_q); // R11
  AST_HW_BLOCKS_GATE: assert property (@(posedge clk) disable iff (!rst_sn)
    hw_q |-> !gate_on); // R11
  AST_PG_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (!load_above_hi_i && !load_below_lo_i) |=> $stable(pg_q)); // R10
  AST_QUIET_BEFORE_POR: assert property (@(posedge clk) disable iff (!rst_sn)
    !por_done |-> (!pg_q && !hw_q)); // R1

endmodule

// File: tb/test_hotswap_breaker.sv
`timescale 1ns/1ps
module test_hotswap_breaker;
  localparam int CUR_W   = 10;
  localparam int PLIM    = 100;
  localparam int PCYC    = 16;
  localparam int RCYC    = 20;
  localparam int ENL     = 4;
  localparam int PORC    = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             enable_i, retry_mode_i;
  logic [1:0]       thr_sel_i;
  logic [CUR_W-1:0] load_current_i;
  logic             supply_ok_i, load_above_hi_i, load_below_lo_i, hw_fault_i;
  logic             gate_on_o, discharge_o, ifault_o, pgood_o, hwfault_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  hotswap_breaker #(
    .CUR_W(CUR_W), .PRI_LIMIT(PLIM), .PRI_CYCLES(PCYC), .RETRY_CYCLES(RCYC),
    .ENL_MIN(ENL), .POR_CYCLES(PORC), .PG_ACT_HIGH(1'b0),
    .IFLT_ACT_HIGH(1'b1), .HWF_ACT_HIGH(1'b1)
  ) i_hotswap_breaker (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .retry_mode_i(retry_mode_i),
    .thr_sel_i(thr_sel_i), .load_current_i(load_current_i),
    .supply_ok_i(supply_ok_i), .load_above_hi_i(load_above_hi_i),
    .load_below_lo_i(load_below_lo_i), .hw_fault_i(hw_fault_i),
    .gate_on_o(gate_on_o), .discharge_o(discharge_o), .ifault_o(ifault_o),
    .pgood_o(pgood_o), .hwfault_o(hwfault_o)
  );

  function automatic int mult20(input logic [1:0] s);
    case (s)
      2'b00: return 26;
      2'b01: return 30;
      2'b10: return 40;
      default: return 35;
    endcase
  endfunction

  function automatic bit exp_sec_trip(input int cur, input logic [1:0] s);
    return (cur * 20) > (PLIM * mult20(s));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm();
    enable_i = 1'b0;
    cyc(ENL);
    enable_i = 1'b1;
    cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable_i = 1'b0; retry_mode_i = 1'b0; thr_sel_i = 2'b00;
    load_current_i = '0; supply_ok_i = 1'b1; load_above_hi_i = 1'b0;
    load_below_lo_i = 1'b0; hw_fault_i = 1'b0;
    cyc(3);
    chk("R1 gate in reset", gate_on_o, 0);
    chk("R1 discharge in reset", discharge_o, 1);
    rst_n = 1'b1;
    cyc(2);
    enable_i = 1'b1;
    load_above_hi_i = 1'b1;
    cyc(1);
    chk("R1 early rise ignored", gate_on_o, 0);
    chk("R1 ifault quiet", ifault_o, 0);
    chk("R1 pgood quiet (active-low R12)", pgood_o, 1);
    load_above_hi_i = 1'b0;
    cyc(15);
    chk("R1 no late start", gate_on_o, 0);
    chk("R1 hwfault quiet", hwfault_o, 0);

    // R2: supply out of window blocks start
    supply_ok_i = 1'b0;
    rearm();
    chk("R2 start blocked by supply", gate_on_o, 0);
    supply_ok_i = 1'b1;
    enable_i = 1'b0; cyc(1); enable_i = 1'b1; cyc(1);
    chk("R2 start gate", gate_on_o, 1);
    chk("R2 start discharge", discharge_o, 0);

    // R4/R8: secondary limit per select, at and above the limit
    for (int s = 0; s < 4; s++) begin
      int thr;
      thr = PLIM * mult20(s[1:0]) / 20;
      thr_sel_i = s[1:0];
      load_current_i = CUR_W'(thr);
      cyc(1);
      chk("R4 at limit holds", gate_on_o, 1);
      load_current_i = CUR_W'(thr + 1);
      cyc(1);
      chk("R4 above limit trips", gate_on_o, 0);
      chk("R8 ifault on trip", ifault_o, 1);
      chk("R4 discharge on trip", discharge_o, 1);
      load_current_i = '0;
      rearm();
      chk("R6 rearm closes", gate_on_o, 1);
      chk("R8 rearm clears ifault", ifault_o, 0);
    end

    // R6: latch-off and short low pulse
    load_current_i = CUR_W'(300);
    cyc(1);
    load_current_i = '0;
    cyc(30);
    chk("R6 stays latched", gate_on_o, 0);
    chk("R8 ifault held", ifault_o, 1);
    enable_i = 1'b0; cyc(ENL - 1); enable_i = 1'b1; cyc(1);
    chk("R6 short pulse ignored", gate_on_o, 0);
    cyc(3);
    chk("R6 still latched", ifault_o, 1);
    rearm();
    chk("R6 full pulse rearms", gate_on_o, 1);

    // R5: primary timing with a dip
    thr_sel_i = 2'b10;
    load_current_i = CUR_W'(120);
    cyc(PCYC - 1);
    chk("R5 before primary time", gate_on_o, 1);
    load_current_i = CUR_W'(50);
    cyc(1);
    load_current_i = CUR_W'(120);
    cyc(PCYC - 1);
    chk("R5 dip restarted count", gate_on_o, 1);
    cyc(1);
    chk("R5 primary trip", gate_on_o, 0);
    chk("R8 primary ifault", ifault_o, 1);
    load_current_i = '0;
    rearm();

    // R7: auto-retry
    retry_mode_i = 1'b1;
    load_current_i = CUR_W'(300);
    cyc(1);
    chk("R7 trip", gate_on_o, 0);
    load_current_i = '0;
    cyc(RCYC - 1);
    chk("R7 still cooling", gate_on_o, 0);
    chk("R7 ifault while cooling", ifault_o, 1);
    cyc(1);
    chk("R7 restart", gate_on_o, 1);
    chk("R7 ifault cleared", ifault_o, 0);
    retry_mode_i = 1'b0;

    // R3: enable low
    enable_i = 1'b0;
    cyc(1);
    chk("R3 gate off", gate_on_o, 0);
    chk("R3 discharge on", discharge_o, 1);
    enable_i = 1'b1;
    cyc(1);
    chk("R2 restart", gate_on_o, 1);

    // R9: supply window loss
    supply_ok_i = 1'b0;
    cyc(1);
    chk("R9 gate off", gate_on_o, 0);
    chk("R9 discharge on", discharge_o, 1);
    supply_ok_i = 1'b1;
    cyc(3);
    chk("R9 no auto restart", gate_on_o, 0);
    enable_i = 1'b0; cyc(1); enable_i = 1'b1; cyc(1);
    chk("R9 restart by edge", gate_on_o, 1);

    // R10/R12: power-good hysteresis, active-low build
    load_above_hi_i = 1'b1; cyc(1); load_above_hi_i = 1'b0;
    chk("R10 R12 pgood set", pgood_o, 0);
    cyc(5);
    chk("R10 pgood hold", pgood_o, 0);
    load_below_lo_i = 1'b1; cyc(1); load_below_lo_i = 1'b0;
    chk("R10 R12 pgood clear", pgood_o, 1);
    cyc(3);
    chk("R10 pgood hold low", pgood_o, 1);

    // Random single-sample pulses against the secondary model
    void'($urandom(32'd1234));
    for (int k = 0; k < 300; k++) begin
      int cur;
      bit t;
      cur = int'($urandom_range(0, 249));
      thr_sel_i = 2'($urandom_range(0, 3));
      t = exp_sec_trip(cur, thr_sel_i);
      load_current_i = CUR_W'(cur);
      cyc(1);
      chk("R4 random trip", gate_on_o, t ? 0 : 1);
      chk("R8 random ifault", ifault_o, t ? 1 : 0);
      load_current_i = '0;
      if (t) begin
        rearm();
        chk("R6 random rearm", gate_on_o, 1);
      end else begin
        cyc(1);
      end
    end

    // R11: hardware fault latch
    hw_fault_i = 1'b1;
    cyc(1);
    hw_fault_i = 1'b0;
    chk("R11 hwfault set", hwfault_o, 1);
    chk("R11 gate off", gate_on_o, 0);
    rearm();
    chk("R11 no restart", gate_on_o, 0);
    chk("R11 hwfault held", hwfault_o, 1);
    rst_n = 1'b0;
    cyc(2);
    chk("R11 reset clears", hwfault_o, 0);
    rst_n = 1'b1;
    cyc(2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule